// File: doc/BRIEF.md
# Configuration Status Interrupt Monitor

This block watches a fixed set of twelve configuration-status signals coming from a programmable-logic fabric and folds them into a single interrupt request. Each input is first brought into the local clock domain by a two-flop synchronizer. Software then picks, per bit, whether the input raises a request while it sits at its active value (level type) or only when it moves into its active value (edge type). It also picks which value counts as active, whether the bit may raise anything at all, and whether the result is hidden from the interrupt line.

The source assignment is fixed by wiring. Bit 0 is the fabric status flag (active low on the wire), bit 1 is configuration done, and bit 2 is initialization done. Bit 3 is the CRC error flag, and bit 4 is configuration-via-protocol done. Bits 5, 6 and 7 are the partial-reconfiguration ready, error and done flags. Bits 8 to 10 mirror the configuration-request, status and done pins, and bit 11 is fabric power-on.

Software uses a simple word-indexed register port with one write strobe and a combinational read. It can look at the raw event bits, the masked event bits and the synchronized input values. It acknowledges latched edge events by writing ones to an acknowledge register. A typical flow waits for configuration done by enabling bit 1 as a rising-edge source, waiting for the line, then acknowledging it.

Top module: `mon_irq_ctrl`

## Requirements
- R1: Reset clears the enable, mask, type and polarity registers and every latched edge event, and holds `irq_o` low. After reset, with all inputs low, the raw status reads 0xFFF, because every bit is then a level source with active-low polarity.
- R2: The synchronized input value read at register index 7 equals the input value as it was two clock edges earlier. It still shows the old value after only one edge.
- R3: A bit whose type bit is 0 (level) reads in the raw status (index 5) as 1 exactly while its synchronized input equals its active value. It follows the input in both directions, and writing the acknowledge register does not change it.
- R4: A polarity bit (index 3) of 1 makes the active value 1 and the active edge rising. A polarity bit of 0 makes the active value 0 and the active edge falling.
- R5: A bit whose type bit is 1 (edge) sets its raw status bit on the active edge of its synchronized input. The bit stays set after the input returns, until it is acknowledged.
- R6: Writing to the acknowledge register (index 6) clears the latched edge bits at the positions written as 1. All other latched bits are left unchanged.
- R7: The masked status (index 4) is the raw status AND the enable register (index 0) AND NOT the mask register (index 1).
- R8: `irq_o` is high exactly when any masked status bit is 1.
- R9: An edge-type bit whose enable bit is 0 does not latch an active edge. Setting the enable bit later does not recover that missed edge.
- R10: Writes to indexes 4, 5 and 7 have no effect, and index 6 always reads as 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Block clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| mon_in | input | 12 | Raw configuration-status inputs, asynchronous to clk |
| bus_wr | input | 1 | Register write strobe, one cycle per write |
| bus_addr | input | 3 | Register word index: 0 enable, 1 mask, 2 type, 3 polarity, 4 masked, 5 raw, 6 acknowledge, 7 inputs |
| bus_wdata | input | 12 | Register write data |
| bus_rdata | output | 12 | Register read data, combinational on bus_addr |
| irq_o | output | 1 | Combined interrupt request |

## Verification
A stuck or lost edge latch shows up in the raw status read within three clock edges of the input change, and it persists until the bit is acknowledged. Because of that, a missed set or a missed clear can be seen on the next read of index 5. A wrong synchronizer depth shifts the input-read value by one edge, which the test checks at the exact edge boundary. A wrong enable or mask term shows up at once in the masked read and on `irq_o`, because both are combinational from the stored state.

// File: rtl/mon_irq_pkg.sv
package mon_irq_pkg;

  localparam int unsigned MON_SRC_COUNT = 12;
  localparam int unsigned REG_AW        = 3;

  typedef logic [REG_AW-1:0] reg_addr_t;

  // Register word indexes
  localparam reg_addr_t A_ENABLE = 3'd0;
  localparam reg_addr_t A_MASK   = 3'd1;
  localparam reg_addr_t A_TYPE   = 3'd2;
  localparam reg_addr_t A_POLAR  = 3'd3;
  localparam reg_addr_t A_MASKED = 3'd4;
  localparam reg_addr_t A_RAW    = 3'd5;
  localparam reg_addr_t A_ACK    = 3'd6;
  localparam reg_addr_t A_PINS   = 3'd7;

endpackage

// File: rtl/mon_sync.sv
module mon_sync #(
  parameter int unsigned W      = 12,
  parameter int unsigned STAGES = 2
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic [W-1:0] d_i,
  output logic [W-1:0] q_o
);

  logic [W-1:0] stg_q [STAGES];

  for (genvar s = 0; s < STAGES; s++) begin : g_stage
    logic [W-1:0] stg_d;
    if (s == 0) begin : g_first
      assign stg_d = d_i;
    end else begin : g_next
      assign stg_d = stg_q[s-1];
    end

    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
        stg_q[s] <= '0;
      end else begin
        stg_q[s] <= stg_d;
      end
    end
  end

  assign q_o = stg_q[STAGES-1];

endmodule

// File: rtl/mon_cfg_regs.sv
module mon_cfg_regs
  import mon_irq_pkg::*;
#(
  parameter int unsigned W = 12
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         wr_i,
  input  reg_addr_t    addr_i,
  input  logic [W-1:0] wdata_i,
  output logic [W-1:0] en_o,
  output logic [W-1:0] msk_o,
  output logic [W-1:0] typ_o,
  output logic [W-1:0] pol_o,
  output logic [W-1:0] ack_o
);

  logic ld_en, ld_msk, ld_typ, ld_pol;

  // Load enables (clock enables for the four writable registers)
  always_comb begin
    ld_en  = wr_i && (addr_i == A_ENABLE);
    ld_msk = wr_i && (addr_i == A_MASK);
    ld_typ = wr_i && (addr_i == A_TYPE);
    ld_pol = wr_i && (addr_i == A_POLAR);
  end

  // Acknowledge is a one-cycle pulse vector, not stored
  assign ack_o = (wr_i && (addr_i == A_ACK)) ? wdata_i : '0;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      en_o <= '0;
    end else if (ld_en) begin
      en_o <= wdata_i;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      msk_o <= '0;
    end else if (ld_msk) begin
      msk_o <= wdata_i;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      typ_o <= '0;
    end else if (ld_typ) begin
      typ_o <= wdata_i;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      pol_o <= '0;
    end else if (ld_pol) begin
      pol_o <= wdata_i;
    end
  end

endmodule

// File: rtl/mon_event.sv
module mon_event #(
  parameter int unsigned W = 12
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic [W-1:0] sync_i,
  input  logic [W-1:0] typ_i,
  input  logic [W-1:0] pol_i,
  input  logic [W-1:0] en_i,
  input  logic [W-1:0] ack_i,
  output logic [W-1:0] raw_o,
  output logic [W-1:0] lat_o
);

  logic [W-1:0] prev_q;
  logic [W-1:0] lat_q;
  logic [W-1:0] lat_d;
  logic [W-1:0] active;
  logic [W-1:0] hit;

  for (genvar g = 0; g < W; g++) begin : g_bit
    // Active value and active edge selected by polarity
    assign active[g] = pol_i[g] ? sync_i[g] : ~sync_i[g];
    assign hit[g]    = pol_i[g] ? (sync_i[g] & ~prev_q[g])
                                : (~sync_i[g] & prev_q[g]);
    // Edge latch: held until acknowledged, set only while enabled,
    // forced clear while the bit is configured as level type
    assign lat_d[g]  = typ_i[g] ? ((lat_q[g] & ~ack_i[g]) | (hit[g] & en_i[g]))
                                : 1'b0;
    assign raw_o[g]  = typ_i[g] ? lat_q[g] : active[g];
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      prev_q <= '0;
      lat_q  <= '0;
    end else begin
      prev_q <= sync_i;
      lat_q  <= lat_d;
    end
  end

  assign lat_o = lat_q;

endmodule

// File: rtl/mon_irq_ctrl.sv
module mon_irq_ctrl
  import mon_irq_pkg::*;
#(
  parameter int unsigned N_SRC       = MON_SRC_COUNT,
  parameter int unsigned SYNC_STAGES = 2
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [N_SRC-1:0] mon_in,
  input  logic             bus_wr,
  input  logic [2:0]       bus_addr,
  input  logic [N_SRC-1:0] bus_wdata,
  output logic [N_SRC-1:0] bus_rdata,
  output logic             irq_o
);

  logic [N_SRC-1:0] sync_q;
  logic [N_SRC-1:0] en_q, msk_q, typ_q, pol_q;
  logic [N_SRC-1:0] ack_bits;
  logic [N_SRC-1:0] raw_stat, lat_q, masked;

  mon_sync #(.W(N_SRC), .STAGES(SYNC_STAGES)) u_sync (
    .clk   (clk),
    .rst_n (rst_n),
    .d_i   (mon_in),
    .q_o   (sync_q)
  );

  mon_cfg_regs #(.W(N_SRC)) u_cfg (
    .clk     (clk),
    .rst_n   (rst_n),
    .wr_i    (bus_wr),
    .addr_i  (bus_addr),
    .wdata_i (bus_wdata),
    .en_o    (en_q),
    .msk_o   (msk_q),
    .typ_o   (typ_q),
    .pol_o   (pol_q),
    .ack_o   (ack_bits)
  );

  mon_event #(.W(N_SRC)) u_event (
    .clk    (clk),
    .rst_n  (rst_n),
    .sync_i (sync_q),
    .typ_i  (typ_q),
    .pol_i  (pol_q),
    .en_i   (en_q),
    .ack_i  (ack_bits),
    .raw_o  (raw_stat),
    .lat_o  (lat_q)
  );

  assign masked = raw_stat & en_q & ~msk_q;
  assign irq_o  = |masked;

  always_comb begin
    unique case (bus_addr)
      A_ENABLE: bus_rdata = en_q;
      A_MASK:   bus_rdata = msk_q;
      A_TYPE:   bus_rdata = typ_q;
      A_POLAR:  bus_rdata = pol_q;
      A_MASKED: bus_rdata = masked;
      A_RAW:    bus_rdata = raw_stat;
      A_ACK:    bus_rdata = '0;
      default:  bus_rdata = sync_q;
    endcase
  end

endmodule

// File: rtl/mon_irq_ctrl_chk.sv
module mon_irq_ctrl_chk
  import mon_irq_pkg::*;
#(
  parameter int unsigned N_SRC = MON_SRC_COUNT
) (
  input logic             clk,
  input logic             rst_n,
  input logic [N_SRC-1:0] mon_in,
  input logic [2:0]       bus_addr,
  input logic [N_SRC-1:0] bus_rdata,
  input logic             irq_o,
  input logic [N_SRC-1:0] sync_q,
  input logic [N_SRC-1:0] en_q,
  input logic [N_SRC-1:0] msk_q,
  input logic [N_SRC-1:0] typ_q,
  input logic [N_SRC-1:0] lat_q,
  input logic [N_SRC-1:0] ack_bits
);

  logic [1:0] since_rst;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      since_rst <= '0;
    end else if (since_rst != 2'd2) begin
      since_rst <= since_rst + 2'd1;
    end
  end

  assert_sync_depth_R2: assert property (@(posedge clk) disable iff (!rst_n)
    (since_rst == 2'd2) |-> (sync_q == $past(mon_in, 2)));

  assert_latch_hold_R5: assert property (@(posedge clk) disable iff (!rst_n)
    (($past(lat_q) & $past(typ_q) & ~$past(ack_bits) & ~lat_q) == '0));

  assert_no_latch_disabled_R9: assert property (@(posedge clk) disable iff (!rst_n)
    ((lat_q & ~$past(lat_q) & ~$past(en_q)) == '0));

  assert_masked_hidden_R7: assert property (@(posedge clk) disable iff (!rst_n)
    (bus_addr == A_MASKED) |-> ((bus_rdata & (msk_q | ~en_q)) == '0));

  assert_irq_needs_enable_R8: assert property (@(posedge clk) disable iff (!rst_n)
    irq_o |-> (|(en_q & ~msk_q)));

  assert_ack_reads_zero_R10: assert property (@(posedge clk) disable iff (!rst_n)
    (bus_addr == A_ACK) |-> (bus_rdata == '0));

endmodule

bind mon_irq_ctrl mon_irq_ctrl_chk #(.N_SRC(N_SRC)) u_chk (
  .clk       (clk),
  .rst_n     (rst_n),
  .mon_in    (mon_in),
  .bus_addr  (bus_addr),
  .bus_rdata (bus_rdata),
  .irq_o     (irq_o),
  .sync_q    (sync_q),
  .en_q      (en_q),
  .msk_q     (msk_q),
  .typ_q     (typ_q),
  .lat_q     (lat_q),
  .ack_bits  (ack_bits)
);

// File: tb/test_mon_irq_ctrl.sv
module test_mon_irq_ctrl;
  import mon_irq_pkg::*;

  localparam int N = 12;

  logic          clk = 1'b0;
  logic          rst_n = 1'b0;
  logic [N-1:0]  mon_in = '0;
  logic          bus_wr = 1'b0;
  logic [2:0]    bus_addr = 3'd0;
  logic [N-1:0]  bus_wdata = '0;
  logic [N-1:0]  bus_rdata;
  logic          irq_o;

  int n_vec = 0;
  int n_bad = 0;

  always #2 clk = ~clk;  // 250 MHz

  mon_irq_ctrl i_mon_irq_ctrl (
    .clk       (clk),
    .rst_n     (rst_n),
    .mon_in    (mon_in),
    .bus_wr    (bus_wr),
    .bus_addr  (bus_addr),
    .bus_wdata (bus_wdata),
    .bus_rdata (bus_rdata),
    .irq_o     (irq_o)
  );

  // Vector: {op[1:0], req[3:0], addr[2:0], data[11:0]}
  localparam logic [1:0] OP_WR = 2'd0, OP_IN = 2'd1, OP_RD = 2'd2, OP_IRQ = 2'd3;
  localparam int NV = 41;
  localparam logic [20:0] VEC [NV] = '{
    {OP_IN,  4'd3,  A_PINS,   12'h000},
    {OP_WR,  4'd4,  A_POLAR,  12'hFFF},
    {OP_RD,  4'd4,  A_RAW,    12'h000},  // R4 active-high, inputs low
    {OP_IN,  4'd3,  A_PINS,   12'h00A},
    {OP_RD,  4'd3,  A_RAW,    12'h00A},  // R3
    {OP_RD,  4'd2,  A_PINS,   12'h00A},  // R2
    {OP_RD,  4'd7,  A_MASKED, 12'h000},  // R7 nothing enabled
    {OP_IRQ, 4'd8,  A_PINS,   12'h000},  // R8
    {OP_WR,  4'd7,  A_ENABLE, 12'h00F},
    {OP_RD,  4'd7,  A_MASKED, 12'h00A},  // R7
    {OP_IRQ, 4'd8,  A_PINS,   12'h001},  // R8
    {OP_WR,  4'd7,  A_MASK,   12'h00A},
    {OP_RD,  4'd7,  A_MASKED, 12'h000},  // R7 all masked
    {OP_IRQ, 4'd8,  A_PINS,   12'h000},  // R8
    {OP_WR,  4'd7,  A_MASK,   12'h002},
    {OP_RD,  4'd7,  A_MASKED, 12'h008},  // R7
    {OP_WR,  4'd3,  A_ACK,    12'h008},
    {OP_RD,  4'd3,  A_RAW,    12'h00A},  // R3 ack ignored on level
    {OP_IN,  4'd3,  A_PINS,   12'h002},
    {OP_RD,  4'd3,  A_RAW,    12'h002},  // R3 follows input down
    {OP_WR,  4'd7,  A_MASK,   12'h000},
    {OP_WR,  4'd5,  A_TYPE,   12'h030},
    {OP_WR,  4'd4,  A_POLAR,  12'hFDF},
    {OP_WR,  4'd5,  A_ENABLE, 12'h03F},
    {OP_RD,  4'd5,  A_RAW,    12'h002},  // R5 no edge yet
    {OP_IN,  4'd5,  A_PINS,   12'h032},
    {OP_RD,  4'd5,  A_RAW,    12'h012},  // R5 rising latched, R4 bit5 ignores rise
    {OP_IN,  4'd5,  A_PINS,   12'h002},
    {OP_RD,  4'd4,  A_RAW,    12'h032},  // R4 falling latched, R5 held
    {OP_RD,  4'd7,  A_MASKED, 12'h032},  // R7
    {OP_WR,  4'd6,  A_ACK,    12'h010},
    {OP_RD,  4'd6,  A_RAW,    12'h022},  // R6 only bit4 cleared
    {OP_WR,  4'd6,  A_ACK,    12'h020},
    {OP_RD,  4'd6,  A_RAW,    12'h002},  // R6
    {OP_WR,  4'd9,  A_ENABLE, 12'h00F},
    {OP_IN,  4'd9,  A_PINS,   12'h012},
    {OP_WR,  4'd9,  A_ENABLE, 12'h03F},
    {OP_RD,  4'd9,  A_RAW,    12'h002},  // R9 missed edge not latched
    {OP_WR,  4'd10, A_RAW,    12'hFFF},
    {OP_RD,  4'd10, A_RAW,    12'h002},  // R10 read-only write ignored
    {OP_RD,  4'd10, A_ACK,    12'h000}   // R10 ack reads zero
  };

  task automatic check(input int req, input string what,
                       input logic [N-1:0] act, input logic [N-1:0] exp);
    n_vec++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL R%0d %s: actual %h expected %h", req, what, act, exp);
    end
  endtask

  task automatic rd(input logic [2:0] a, output logic [N-1:0] v);
    @(negedge clk);
    bus_addr = a;
    #1;
    v = bus_rdata;
  endtask

  task automatic wr(input logic [2:0] a, input logic [N-1:0] d);
    @(negedge clk);
    bus_wr = 1'b1;
    bus_addr = a;
    bus_wdata = d;
    @(negedge clk);
    bus_wr = 1'b0;
  endtask

  task automatic finish_run();
    $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
    $finish;
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    n_vec++;
    n_bad++;
    $display("FAIL R1 watchdog: actual hung expected done");
    finish_run();
  end

  initial begin
    logic [N-1:0] v;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;

    // R1 reset state
    rd(A_ENABLE, v); check(1, "enable after reset", v, '0);
    rd(A_MASK,   v); check(1, "mask after reset",   v, '0);
    rd(A_TYPE,   v); check(1, "type after reset",   v, '0);
    rd(A_POLAR,  v); check(1, "polarity after reset", v, '0);
    rd(A_RAW,    v); check(1, "raw after reset",    v, 12'hFFF);
    check(1, "irq after reset", {11'd0, irq_o}, '0);

    for (int i = 0; i < NV; i++) begin
      logic [1:0]   op;
      logic [3:0]   rq;
      logic [2:0]   ad;
      logic [N-1:0] dt;
      {op, rq, ad, dt} = VEC[i];
      case (op)
        OP_WR: wr(ad, dt);
        OP_IN: begin
          @(negedge clk);
          mon_in = dt;
          repeat (4) @(negedge clk);
        end
        OP_RD: begin
          rd(ad, v);
          check(int'(rq), "table read", v, dt);
        end
        default: begin
          @(negedge clk);
          check(int'(rq), "table irq", {11'd0, irq_o}, dt);
        end
      endcase
    end

    // R2 exact synchronizer depth
    @(negedge clk);
    mon_in = 12'h812;
    bus_addr = A_PINS;
    @(negedge clk);
    check(2, "pins after one edge", bus_rdata, 12'h012);
    @(negedge clk);
    check(2, "pins after two edges", bus_rdata, 12'h812);

    // R5 latch survives input return, then R1 mid-run reset clears it
    @(negedge clk); mon_in = 12'h002;  // bit4 falls
    repeat (4) @(negedge clk);
    mon_in = 12'h012;                   // bit4 rises
    repeat (4) @(negedge clk);
    mon_in = 12'h002;
    repeat (4) @(negedge clk);
    rd(A_RAW, v); check(5, "latch held after pulse", v, 12'h012);
    check(8, "irq from latched edge", {11'd0, irq_o}, 12'h001);

    @(negedge clk); rst_n = 1'b0;
    @(negedge clk); rst_n = 1'b1;
    rd(A_TYPE, v); check(1, "type after second reset", v, '0);
    rd(A_ENABLE, v); check(1, "enable after second reset", v, '0);
    check(1, "irq after second reset", {11'd0, irq_o}, '0);

    finish_run();
  end

endmodule